// File: doc/BRIEF.md
# Front-Panel Key Ladder Decoder

This block turns the front-panel key ladder into key presses. The panel keys pull one analog node to different voltages. An external converter delivers that voltage as an unsigned 7-bit sample in steps of 1/128 of the supply, together with a valid strobe. The block keeps the most recent valid sample. A free-running divider produces a scan tick, once per 20 ms in the product. On each tick the held sample is classified into one of six key bands, one of two idle bands, or an invalid reading.

A classification takes effect only when two scans in a row agree. When a key is accepted, the block raises its held key code and gives a one-clock press event. A higher key pre-empts a lower one, and a lower key cannot displace a higher one. The held code returns to zero only when an idle reading has been accepted. The two idle bands also carry a board option: the upper idle band means an S-video input is fitted. The option flag is re-read only when an idle reading is accepted, so it cannot change while a key is down.

Top module: `keyladder_decoder`

## Requirements
- R1: After reset, key_code is 0, key_event is 0 and svideo_fitted is 0.
- R2: A sample s with 29 <= s < 127 decodes to key code 1 + (s-29)/16, with integer division, capped at 6. The bands are 29..44 for 1, 45..60 for 2, 61..76 for 3, 77..92 for 4, 93..108 for 5 and 109..126 for 6. Each lower bound is inclusive.
- R3: The held sample is classified once per scan tick, one tick every SCAN_DIV clocks. A classification is accepted only when two consecutive scan ticks give the same class. The earliest an output can change is therefore SCAN_DIV clocks after a new sample.
- R4: If the classification changes on every scan tick, nothing is accepted, and key_code and svideo_fitted keep their values.
- R5: A sample of 127 is invalid. It is never accepted, and it leaves key_code and svideo_fitted unchanged.
- R6: key_event is high for exactly one clock, in the cycle where key_code first shows a new, higher non-zero code. It is never high otherwise.
- R7: While a key is held, an accepted lower key is ignored and gives no event. An accepted higher key replaces the held code. key_code returns to 0 only when an idle class is accepted.
- R8: A sample below 29 is idle and decodes to key_code 0. If the sample is below 13, an accepted idle sets svideo_fitted to 0. If the sample is 13..28, an accepted idle sets svideo_fitted to 1.
- R9: svideo_fitted changes only when an idle class is accepted. While key_code is non-zero, it holds its value.
- R10: A sample presented with sample_valid low is ignored, and the last valid sample remains in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample | input | 7 | Ladder voltage in 1/128 steps of the supply |
| sample_valid | input | 1 | Strobe: sample is captured when high |
| key_code | output | 3 | Held debounced key, 0 = none, 1..6 = K1..K6 |
| key_event | output | 1 | One-clock pulse when a new higher key is accepted |
| svideo_fitted | output | 1 | Board option read from the idle band |

## Verification
Two functions can act on the same scan tick: accepting a key, which rewrites key_code and may pulse key_event, and re-evaluating the option flag. The bench provokes them together in two ways. It sweeps every sample value from both an absent-option idle and a present-option idle. It also holds a key after each idle variant. After every step it judges key_code, the number of events and svideo_fitted against values computed from the band arithmetic. An option change that slips through while a key is accepted shows up as a wrong flag. Separate runs alternate classes on every scan, and present invalid or unstrobed samples, to show that the same tick can also refuse both updates.

// File: rtl/keyladder_pkg.sv
package keyladder_pkg;
  localparam int SMP_W      = 7;
  localparam int IDLE_SPLIT = 13;
  localparam int KEY_BASE   = 29;
  localparam int BAND_STEP  = 16;
  localparam int NUM_KEYS   = 6;
  localparam int INVALID_AT = 127;
  localparam int KEY_W      = $clog2(NUM_KEYS + 1);

  typedef enum logic [3:0] {
    CL_IDLE_LO = 4'd0,
    CL_IDLE_HI = 4'd1,
    CL_K1      = 4'd2,
    CL_K2      = 4'd3,
    CL_K3      = 4'd4,
    CL_K4      = 4'd5,
    CL_K5      = 4'd6,
    CL_K6      = 4'd7,
    CL_BAD     = 4'd8
  } cls_e;

  // Band arithmetic: idle split, then equal-width key bands, top band clipped.
  function automatic cls_e classify(input logic [SMP_W-1:0] s);
    int v;
    int idx;
    v = int'(s);
    if (v < IDLE_SPLIT) return CL_IDLE_LO;
    if (v < KEY_BASE)   return CL_IDLE_HI;
    if (v >= INVALID_AT) return CL_BAD;
    idx = (v - KEY_BASE) / BAND_STEP;
    if (idx > NUM_KEYS - 1) idx = NUM_KEYS - 1;
    return cls_e'(4'(idx + int'(CL_K1)));
  endfunction

  function automatic logic is_idle(input cls_e c);
    return (c == CL_IDLE_LO) || (c == CL_IDLE_HI);
  endfunction

  function automatic logic [KEY_W-1:0] key_of(input cls_e c);
    if (c >= CL_K1 && c <= CL_K6) return KEY_W'(int'(c) - int'(CL_K1) + 1);
    return '0;
  endfunction
endpackage

// File: rtl/keyladder_scan_timer.sv
module keyladder_scan_timer #(
  parameter int SCAN_DIV = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCAN_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/keyladder_debounce.sv
module keyladder_debounce
  import keyladder_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cls_e             cls_in,
  output logic [KEY_W-1:0] key_code,
  output logic             key_event,
  output logic             opt_fitted,
  output logic             accept
);
  cls_e             prev_cls;
  logic [KEY_W-1:0] cand_key;

  assign cand_key = key_of(cls_in);
  assign accept   = tick && (cls_in == prev_cls) && (cls_in != CL_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cls   <= CL_BAD;
      key_code   <= '0;
      key_event  <= 1'b0;
      opt_fitted <= 1'b0;
    end else begin
      key_event <= 1'b0;
      if (tick) prev_cls <= cls_in;
      if (accept) begin
        if (is_idle(cls_in)) begin
          key_code   <= '0;
          opt_fitted <= (cls_in == CL_IDLE_HI);
        end else if (cand_key > key_code) begin
          key_code  <= cand_key;
          key_event <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyladder_decoder.sv
module keyladder_decoder
  import keyladder_pkg::*;
#(
  parameter int SCAN_DIV = 1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] sample,
  input  logic             sample_valid,
  output logic [KEY_W-1:0] key_code,
  output logic             key_event,
  output logic             svideo_fitted
);
  logic [SMP_W-1:0] held_sample;
  logic             scan_tick;
  cls_e             cls_now;
  logic             accept_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            held_sample <= '0;
    else if (sample_valid) held_sample <= sample;
  end

  assign cls_now = classify(held_sample);

  keyladder_scan_timer #(.SCAN_DIV(SCAN_DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (scan_tick)
  );

  keyladder_debounce u_deb (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (scan_tick),
    .cls_in     (cls_now),
    .key_code   (key_code),
    .key_event  (key_event),
    .opt_fitted (svideo_fitted),
    .accept     (accept_now)
  );
endmodule

// File: rtl/keyladder_chk.sv
module keyladder_chk
  import keyladder_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scan_tick,
  input logic             accept_now,
  input logic [3:0]       cls_now,
  input logic [KEY_W-1:0] key_code,
  input logic             key_event,
  input logic             svideo_fitted
);
  // R3
  held_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(key_code) && $stable(svideo_fitted));

  // R5
  invalid_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && cls_now == 4'(CL_BAD)) |=> $stable(key_code) && $stable(svideo_fitted));

  // R6
  event_with_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_event |-> (key_code != '0) && (key_code > $past(key_code)));

  // R6
  event_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_event |=> !key_event);

  // R7
  no_lower_takeover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_code != '0) |=> (key_code == '0) || (key_code >= $past(key_code)));

  // R9
  option_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(svideo_fitted) |-> (key_code == '0) && $past(accept_now));
endmodule

bind keyladder_decoder keyladder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scan_tick     (scan_tick),
  .accept_now    (accept_now),
  .cls_now       (cls_now),
  .key_code      (key_code),
  .key_event     (key_event),
  .svideo_fitted (svideo_fitted)
);

// File: tb/tb_keyladder_decoder.sv
module tb_keyladder_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int SETTLE     = 3 * DIV + 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] sample = '0;
  logic       sample_valid = 1'b0;
  logic [2:0] key_code;
  logic       key_event;
  logic       svideo_fitted;

  int checks = 0;
  int failures = 0;
  int events = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyladder_decoder #(.SCAN_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .sample(sample), .sample_valid(sample_valid),
    .key_code(key_code), .key_event(key_event), .svideo_fitted(svideo_fitted)
  );

  always @(posedge clk) if (rst_n && key_event) events++;

  function automatic int exp_key(input int s);
    int k;
    if (s < 29 || s >= 127) return 0;
    k = (s - 29) / 16 + 1;
    return (k > 6) ? 6 : k;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int v);
    @(negedge clk);
    sample = 7'(v);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic apply(input int v);
    put(v);
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ev0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 key_code", key_code, 0);
    check("R1 key_event", key_event, 0);
    check("R1 svideo_fitted", svideo_fitted, 0);
    rst_n = 1'b1;

    // R2 R8 R9: sweep from both idle variants
    for (int base = 0; base < 2; base++) begin
      int idle_v;
      idle_v = (base == 0) ? 5 : 20;
      for (int v = 0; v < 128; v++) begin
        int eo;
        apply(idle_v);
        ev0 = events;
        apply(v);
        check("R2 R8 key_code", key_code, exp_key(v));
        check("R6 event count", events - ev0, (exp_key(v) != 0) ? 1 : 0);
        if (v < 13) eo = 0;
        else if (v < 29) eo = 1;
        else eo = base;
        check("R8 R9 svideo_fitted", svideo_fitted, eo);
      end
    end

    // R3: no change before SCAN_DIV clocks
    apply(5);
    put(80);
    repeat (DIV - 3) @(negedge clk);
    check("R3 early key_code", key_code, 0);
    settle();
    check("R3 accepted key_code", key_code, 4);

    // R4: class alternates every scan
    apply(20);
    ev0 = events;
    sample_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sample = (i % 2 == 0) ? 7'd40 : 7'd100;
      repeat (DIV) @(negedge clk);
    end
    sample = 7'd5;
    sample_valid = 1'b0;
    @(negedge clk);
    check("R4 bounce key_code", key_code, 0);
    check("R4 bounce events", events - ev0, 0);
    check("R4 bounce svideo_fitted", svideo_fitted, 1);

    // R5: invalid reading
    apply(20);
    ev0 = events;
    apply(127);
    check("R5 invalid from idle", key_code, 0);
    check("R5 invalid events", events - ev0, 0);
    check("R5 invalid option", svideo_fitted, 1);
    apply(70);
    apply(127);
    check("R5 invalid while held", key_code, 3);

    // R7: priority
    apply(5);
    apply(50);
    ev0 = events;
    apply(100);
    check("R7 higher replaces", key_code, 5);
    check("R6 higher gives event", events - ev0, 1);
    ev0 = events;
    apply(30);
    check("R7 lower ignored", key_code, 5);
    check("R7 lower no event", events - ev0, 0);
    apply(120);
    check("R7 top key", key_code, 6);
    apply(20);
    check("R7 release", key_code, 0);
    check("R9 option after release", svideo_fitted, 1);

    // R10: unstrobed sample ignored
    ev0 = events;
    @(negedge clk);
    sample = 7'd80;
    sample_valid = 1'b0;
    settle();
    check("R10 unstrobed key_code", key_code, 0);
    check("R10 unstrobed events", events - ev0, 0);
    @(negedge clk);
    sample = 7'd2;
    settle();
    check("R10 unstrobed option", svideo_fitted, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule